// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of a single-rank SDRAM. After reset it waits a configurable settling time with NOP on the bus. It then runs the start-up sequence the memory needs: a precharge of every bank, two auto-refresh cycles and a load of the mode register. Between these commands it leaves the recovery gaps the memory requires. When the sequence ends it raises `init_done` and gives the command bus to the user-side controller.

In normal operation an interval timer adds one refresh to a pending count at a fixed period. The default period is 15.6 µs, which keeps 4096 refreshes inside a 64 ms window. While refreshes are pending, `refresh_req` is high. The user side finishes its work, closes its banks and raises `usr_idle`. The sequencer then takes the bus back for one auto-refresh and its recovery time, and returns the bus afterwards.

If the user side ignores the request until the pending count reaches its ceiling, the sequencer takes the bus without waiting. It closes every bank itself and then refreshes. All timing values are given as parameters in picoseconds (or in clocks where noted) and are turned into clock counts by rounding up. The clock enable pin is held high at all times.

Top module: `sdr_boot_refresh`

## Requirements
- R1: While `rst_n` is low and for the ceil(PWRUP_PS/CLK_PS) cycles after it rises, the pins carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111), `mem_cke` is 1, and `usr_grant`, `init_done` and `refresh_req` are 0.
- R2: The start-up commands appear in this order: precharge (4'b0010), auto refresh (4'b0001), auto refresh (4'b0001), mode register load (4'b0000). Each command lasts one cycle and every other cycle is NOP.
- R3: A sequencer-issued precharge drives address bit 10 high, all other address bits 0 and bank address 0, so it closes all banks.
- R4: The next command comes exactly RP = max(2, ceil(TRP_PS/CLK_PS)) cycles after a precharge and exactly RFC = max(2, ceil(TRFC_PS/CLK_PS)) cycles after an auto refresh.
- R5: During the mode register load, address bits [9:0] equal MODE_WORD, address bits [11:10] are 0 and the bank address is 0.
- R6: `init_done` and `usr_grant` rise MRD = max(2, MRD_CYC) cycles after the mode register load, and `init_done` then stays high.
- R7: Counting from the first cycle with `init_done` high, the pending count grows by one every ceil(REFI_PS/CLK_PS) cycles. `refresh_req` is high whenever the count is non-zero.
- R8: While `usr_grant` is high, the user command, bank and address inputs appear on the pins unchanged in the same cycle. A pending refresh does not take the bus while `usr_idle` is low and the count is below MAX_PEND.
- R9: If a granted cycle has a pending refresh and `usr_idle` high, the next cycle carries an auto refresh with `usr_grant` low. NOPs follow, and `usr_grant` returns RFC cycles after the refresh.
- R10: While `usr_grant` is low, the user command, bank and address inputs have no effect on the pins.
- R11: In the cycle the pending count reaches MAX_PEND, `usr_grant` drops and the pins carry NOP. The next cycle carries a precharge of all banks, and an auto refresh follows RP cycles later.
- R12: Each refresh issued after start-up lowers the pending count by one. `refresh_req` falls once the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every pin changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_cs_n | input | 1 | User command: chip select, active low |
| usr_ras_n | input | 1 | User command: row strobe, active low |
| usr_cas_n | input | 1 | User command: column strobe, active low |
| usr_we_n | input | 1 | User command: write enable, active low |
| usr_ba | input | BA_W | User bank address |
| usr_addr | input | ADDR_W | User address |
| usr_idle | input | 1 | User side has closed all banks and may give up the bus |
| usr_grant | output | 1 | User inputs are driving the pins this cycle |
| refresh_req | output | 1 | One or more refreshes are pending |
| init_done | output | 1 | Start-up sequence complete |
| mem_cke | output | 1 | Memory clock enable, always high |
| mem_cs_n | output | 1 | Memory chip select |
| mem_ras_n | output | 1 | Memory row strobe |
| mem_cas_n | output | 1 | Memory column strobe |
| mem_we_n | output | 1 | Memory write enable |
| mem_ba | output | BA_W | Memory bank address |
| mem_addr | output | ADDR_W | Memory address |

## Verification
The bench walks the start-up sequence cycle by cycle against a table of expected commands. An off-by-one recovery counter would show up as a command one cycle early or late. A wrong opcode or a missing precharge-all bit would show up on the pins. User commands are driven during start-up and during refreshes, so a leaky bus multiplexer would put them on the pins. The bench holds `usr_idle` low after a request to show that the bus stays with the user. It then lets eight refreshes pile up: a design without the ceiling would never take the bus, and a forced path without the precharge would refresh with rows still open. The drain phase crosses a new timer tick, so a pending counter that loses an increment or decrement would end with the wrong number of refreshes or a stuck request.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SDRAM start-up/refresh sequencer.
// Assumes command pins are ordered {cs_n, ras_n, cas_n, we_n}.
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_LOADMODE = 4'b0000,
        CMD_REFRESH  = 4'b0001,
        CMD_PRECHG   = 4'b0010,
        CMD_NOP      = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_SETTLE, ST_PRE_INIT, ST_GAP_RP_INIT,
        ST_REF_A, ST_GAP_A, ST_REF_B, ST_GAP_B,
        ST_LOADMODE, ST_GAP_MRD,
        ST_RUN, ST_PRE_FORCE, ST_GAP_RP_FORCE,
        ST_REF_RUN, ST_GAP_RUN
    } seq_state_e;

    // Convert a time in picoseconds to whole clocks, rounding up.
    function automatic int unsigned ceil_clk(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Enforce the two-cycle floor used by the recovery counters.
    function automatic int unsigned floor_two(input int unsigned v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
// Refresh interval timer and pending-refresh counter.
// Counts only while enabled; one tick every REFI_CYC clocks raises the
// pending count (saturating at MAX_PEND); each served refresh lowers it.
module sdr_refresh_timer #(
    parameter int unsigned REFI_CYC = 2080,
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic served,
    output logic pend_any,
    output logic pend_full
);
    localparam int unsigned TW = (REFI_CYC < 2) ? 1 : $clog2(REFI_CYC);
    localparam int unsigned PW = $clog2(MAX_PEND + 1);

    logic [TW-1:0] ivl_cnt;
    logic [PW-1:0] pend_cnt;
    logic          tick;
    logic          inc;
    logic          dec;

    assign tick      = en && (ivl_cnt == TW'(REFI_CYC - 1));
    assign pend_any  = (pend_cnt != '0);
    assign pend_full = (pend_cnt == PW'(MAX_PEND));
    assign inc       = tick && !pend_full;
    assign dec       = served && pend_any;

    // Interval counter: wraps every REFI_CYC enabled clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ivl_cnt <= '0;
        else if (tick)
            ivl_cnt <= '0;
        else if (en)
            ivl_cnt <= ivl_cnt + 1'b1;
    end

    // Pending count: add on tick, remove on each served refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_cnt <= '0;
        else if (inc && !dec)
            pend_cnt <= pend_cnt + 1'b1;
        else if (dec && !inc)
            pend_cnt <= pend_cnt - 1'b1;
    end
endmodule

// File: rtl/sdr_seq_fsm.sv
`timescale 1ns/1ps
// Command sequencer state machine. Issues the start-up commands with their
// recovery gaps, then arbitrates between the user side and refresh.
// Assumes every gap parameter is at least 2 clocks.
module sdr_seq_fsm
    import sdr_seq_pkg::*;
#(
    parameter int unsigned PWR_CYC = 4,
    parameter int unsigned RP_CYC  = 2,
    parameter int unsigned RFC_CYC = 2,
    parameter int unsigned MRD_CYC = 2,
    parameter int unsigned CW      = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pend_any,
    input  logic     pend_full,
    input  logic     usr_idle,
    output sdr_cmd_e seq_cmd,
    output logic     grant,
    output logic     done,
    output logic     served
);
    seq_state_e    st, nxt;
    logic [CW-1:0] gap_cnt;
    logic [CW-1:0] load_val;
    logic          load;
    logic          gap_last;

    assign gap_last = (gap_cnt <= CW'(1));

    // Next-state and gap-load selection.
    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = '0;
        case (st)
            ST_SETTLE:       if (gap_last) nxt = ST_PRE_INIT;
            ST_PRE_INIT:     begin nxt = ST_GAP_RP_INIT; load = 1'b1; load_val = CW'(RP_CYC - 1); end
            ST_GAP_RP_INIT:  if (gap_last) nxt = ST_REF_A;
            ST_REF_A:        begin nxt = ST_GAP_A; load = 1'b1; load_val = CW'(RFC_CYC - 1); end
            ST_GAP_A:        if (gap_last) nxt = ST_REF_B;
            ST_REF_B:        begin nxt = ST_GAP_B; load = 1'b1; load_val = CW'(RFC_CYC - 1); end
            ST_GAP_B:        if (gap_last) nxt = ST_LOADMODE;
            ST_LOADMODE:     begin nxt = ST_GAP_MRD; load = 1'b1; load_val = CW'(MRD_CYC - 1); end
            ST_GAP_MRD:      if (gap_last) nxt = ST_RUN;
            ST_RUN: begin
                if (pend_full)
                    nxt = ST_PRE_FORCE;
                else if (pend_any && usr_idle)
                    nxt = ST_REF_RUN;
            end
            ST_PRE_FORCE:    begin nxt = ST_GAP_RP_FORCE; load = 1'b1; load_val = CW'(RP_CYC - 1); end
            ST_GAP_RP_FORCE: if (gap_last) nxt = ST_REF_RUN;
            ST_REF_RUN:      begin nxt = ST_GAP_RUN; load = 1'b1; load_val = CW'(RFC_CYC - 1); end
            ST_GAP_RUN:      if (gap_last) nxt = ST_RUN;
            default:         nxt = ST_SETTLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SETTLE;
        else        st <= nxt;
    end

    // Recovery counter; reset value doubles as the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_cnt <= CW'(PWR_CYC);
        else if (load)           gap_cnt <= load_val;
        else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end

    // Start-up complete flag, set once and held.
    always_ff @(posedge clk) begin
        if (!rst_n)                         done <= 1'b0;
        else if (st == ST_GAP_MRD && gap_last) done <= 1'b1;
    end

    // Command decode from state.
    always_comb begin
        case (st)
            ST_PRE_INIT, ST_PRE_FORCE:      seq_cmd = CMD_PRECHG;
            ST_REF_A, ST_REF_B, ST_REF_RUN: seq_cmd = CMD_REFRESH;
            ST_LOADMODE:                    seq_cmd = CMD_LOADMODE;
            default:                        seq_cmd = CMD_NOP;
        endcase
    end

    assign grant  = (st == ST_RUN) && !pend_full;
    assign served = (st == ST_REF_RUN);
endmodule

// File: rtl/sdr_cmd_mux.sv
`timescale 1ns/1ps
// Pin multiplexer: passes the user command through while granted,
// otherwise drives the sequencer command with its fixed address pattern.
// Assumes ADDR_W >= 11 (bit 10 is the all-banks flag).
module sdr_cmd_mux
    import sdr_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 2,
    parameter logic [9:0]  MODE_WORD = 10'h032
) (
    input  logic              grant,
    input  sdr_cmd_e          seq_cmd,
    input  logic              usr_cs_n,
    input  logic              usr_ras_n,
    input  logic              usr_cas_n,
    input  logic              usr_we_n,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned ALL_BANK_BIT = 10;
    localparam int unsigned MODE_W       = 10;

    // Select the pin driver for this cycle.
    always_comb begin
        if (grant) begin
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = {usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n};
            mem_ba   = usr_ba;
            mem_addr = usr_addr;
        end else begin
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = seq_cmd;
            mem_ba   = '0;
            mem_addr = '0;
            if (seq_cmd == CMD_PRECHG)
                mem_addr[ALL_BANK_BIT] = 1'b1;
            else if (seq_cmd == CMD_LOADMODE)
                mem_addr[MODE_W-1:0] = MODE_WORD;
        end
    end
endmodule

// File: rtl/sdr_boot_refresh.sv
`timescale 1ns/1ps
// SDRAM start-up and periodic refresh sequencer (top).
// Timing inputs in picoseconds are rounded up to clocks; recovery gaps
// have a floor of two clocks. CKE is tied high.
module sdr_boot_refresh
    import sdr_seq_pkg::*;
#(
    parameter int unsigned CLK_PS    = 7500,
    parameter int unsigned PWRUP_PS  = 100_000_000,
    parameter int unsigned TRP_PS    = 15000,
    parameter int unsigned TRFC_PS   = 66000,
    parameter int unsigned MRD_CYC   = 2,
    parameter int unsigned REFI_PS   = 15_600_000,
    parameter int unsigned MAX_PEND  = 8,
    parameter logic [9:0]  MODE_WORD = 10'h032,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BA_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_cs_n,
    input  logic              usr_ras_n,
    input  logic              usr_cas_n,
    input  logic              usr_we_n,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic              usr_idle,
    output logic              usr_grant,
    output logic              refresh_req,
    output logic              init_done,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int unsigned PWR_CYC  = ceil_clk(PWRUP_PS, CLK_PS);
    localparam int unsigned RP_CYC   = floor_two(ceil_clk(TRP_PS, CLK_PS));
    localparam int unsigned RFC_CYC  = floor_two(ceil_clk(TRFC_PS, CLK_PS));
    localparam int unsigned MRD_EFF  = floor_two(MRD_CYC);
    localparam int unsigned REFI_CYC = floor_two(ceil_clk(REFI_PS, CLK_PS));
    localparam int unsigned GAP_MAX  = max2(max2(PWR_CYC, RP_CYC), max2(RFC_CYC, MRD_EFF));
    localparam int unsigned CW       = $clog2(GAP_MAX + 1);

    sdr_cmd_e seq_cmd;
    logic     pend_any;
    logic     pend_full;
    logic     served;

    assign mem_cke     = 1'b1;
    assign refresh_req = pend_any;

    sdr_refresh_timer #(
        .REFI_CYC (REFI_CYC),
        .MAX_PEND (MAX_PEND)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (init_done),
        .served    (served),
        .pend_any  (pend_any),
        .pend_full (pend_full)
    );

    sdr_seq_fsm #(
        .PWR_CYC (PWR_CYC),
        .RP_CYC  (RP_CYC),
        .RFC_CYC (RFC_CYC),
        .MRD_CYC (MRD_EFF),
        .CW      (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_any  (pend_any),
        .pend_full (pend_full),
        .usr_idle  (usr_idle),
        .seq_cmd   (seq_cmd),
        .grant     (usr_grant),
        .done      (init_done),
        .served    (served)
    );

    sdr_cmd_mux #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MODE_WORD (MODE_WORD)
    ) u_mux (
        .grant     (usr_grant),
        .seq_cmd   (seq_cmd),
        .usr_cs_n  (usr_cs_n),
        .usr_ras_n (usr_ras_n),
        .usr_cas_n (usr_cas_n),
        .usr_we_n  (usr_we_n),
        .usr_ba    (usr_ba),
        .usr_addr  (usr_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n),
        .mem_we_n  (mem_we_n),
        .mem_ba    (mem_ba),
        .mem_addr  (mem_addr)
    );
endmodule

// File: rtl/sdr_boot_refresh_chk.sv
`timescale 1ns/1ps
// Protocol checker for sdr_boot_refresh: watches the pins and tracks the
// cycles since the last sequencer precharge, refresh and mode load.
module sdr_boot_refresh_chk #(
    parameter int unsigned RP_CYC  = 2,
    parameter int unsigned RFC_CYC = 2,
    parameter int unsigned MRD_CYC = 2,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BA_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [BA_W-1:0]   mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              usr_grant,
    input logic              init_done
);
    logic [3:0]  cmd;
    logic        own_pre, own_ref, own_mrs;
    logic [15:0] since_pre, since_ref, since_mrs;

    assign cmd     = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign own_pre = !usr_grant && (cmd == 4'b0010);
    assign own_ref = !usr_grant && (cmd == 4'b0001);
    assign own_mrs = !usr_grant && (cmd == 4'b0000);

    // Saturating distance counters since each sequencer command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= '1;
            since_ref <= '1;
            since_mrs <= '1;
        end else begin
            since_pre <= own_pre ? 16'd1 : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
            since_ref <= own_ref ? 16'd1 : ((since_ref == '1) ? since_ref : since_ref + 1'b1);
            since_mrs <= own_mrs ? 16'd1 : ((since_mrs == '1) ? since_mrs : since_mrs + 1'b1);
        end
    end

    p_gap_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |-> (since_pre >= 16'(RP_CYC)));
    p_gap_after_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |-> (since_ref >= 16'(RFC_CYC)));
    p_gap_after_mrs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |-> (since_mrs >= 16'(MRD_CYC)));
    p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        own_pre |-> (mem_addr[10] && mem_ba == '0));
    p_mode_high_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        own_mrs |-> (mem_addr[11:10] == 2'b00));
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_grant_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        usr_grant |-> init_done);
endmodule

bind sdr_boot_refresh sdr_boot_refresh_chk #(
    .RP_CYC  (RP_CYC),
    .RFC_CYC (RFC_CYC),
    .MRD_CYC (MRD_EFF),
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr),
    .usr_grant (usr_grant),
    .init_done (init_done)
);

// File: tb/sdr_boot_refresh_test.sv
`timescale 1ns/1ps
// Bench: start-up table walk, then directed refresh and saturation tests.
// Small parameters: 5-cycle settle, RP=2, RFC=7, MRD=2, interval 40.
module sdr_boot_refresh_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] MODE = 10'h032;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000, ACT = 4'b0011;
    // Start-up table: cycle after reset release and expected command.
    localparam int         EV_CYC [4] = '{5, 7, 14, 21};
    localparam logic [3:0] EV_CMD [4] = '{PRE, REF, REF, MRS};

    logic clk = 1'b0;
    logic rst_n;
    logic u_cs, u_ras, u_cas, u_we;
    logic [1:0]  u_ba;
    logic [11:0] u_addr;
    logic usr_idle;
    logic usr_grant, refresh_req, init_done, mem_cke;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]  mem_ba;
    logic [11:0] mem_addr;
    logic [3:0]  pin_cmd;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    assign pin_cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdr_boot_refresh #(
        .CLK_PS(10000), .PWRUP_PS(50000), .TRP_PS(15000), .TRFC_PS(66000),
        .MRD_CYC(2), .REFI_PS(400000), .MAX_PEND(8), .MODE_WORD(MODE),
        .ADDR_W(12), .BA_W(2)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .usr_cs_n(u_cs), .usr_ras_n(u_ras), .usr_cas_n(u_cas), .usr_we_n(u_we),
        .usr_ba(u_ba), .usr_addr(u_addr), .usr_idle(usr_idle),
        .usr_grant(usr_grant), .refresh_req(refresh_req), .init_done(init_done),
        .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic drive_usr(input logic [3:0] c, input logic [1:0] ba, input logic [11:0] a);
        {u_cs, u_ras, u_cas, u_we} = c;
        u_ba   = ba;
        u_addr = a;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    task automatic run_to(input int n);
        while (cyc < n) tick();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ref_cnt;
        logic [3:0] exp_cmd;
        rst_n = 1'b0;
        usr_idle = 1'b0;
        drive_usr(NOP, 2'd0, 12'h000);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset cmd", pin_cmd, NOP);
        chk("R1 reset cke", mem_cke, 1);
        chk("R1 reset done", init_done, 0);
        chk("R1 reset grant", usr_grant, 0);
        chk("R1 reset req", refresh_req, 0);
        // R10: user drives an activate during start-up; it must not reach the pins
        drive_usr(ACT, 2'd3, 12'hABC);
        rst_n = 1'b1;
        cyc = 0;

        for (int c = 1; c <= 24; c++) begin
            tick();
            exp_cmd = NOP;
            for (int e = 0; e < 4; e++)
                if (c == EV_CYC[e]) exp_cmd = EV_CMD[e];
            chk("R1,R2,R4,R10 start-up command", pin_cmd, exp_cmd);
            chk("R1 cke high", mem_cke, 1);
            chk("R6 init_done", init_done, (c >= 23) ? 1 : 0);
            chk("R6 grant", usr_grant, (c >= 23) ? 1 : 0);
            if (c == EV_CYC[0]) begin
                chk("R3 precharge-all addr", mem_addr, 12'h400);
                chk("R3 precharge-all bank", mem_ba, 0);
            end
            if (c == EV_CYC[3]) begin
                chk("R5 mode addr", mem_addr, {2'b00, MODE});
                chk("R5 mode bank", mem_ba, 0);
            end
            if (c == 22) drive_usr(NOP, 2'd0, 12'h000);
        end

        // R8: pass-through of user commands while granted
        drive_usr(ACT, 2'd2, 12'h5A5);
        tick();
        chk("R8 user cmd", pin_cmd, ACT);
        chk("R8 user bank", mem_ba, 2);
        chk("R8 user addr", mem_addr, 12'h5A5);
        drive_usr(PRE, 2'd1, 12'h000);
        tick();
        chk("R8 user precharge", pin_cmd, PRE);
        chk("R8 user precharge addr", mem_addr, 12'h000);
        chk("R8 user precharge bank", mem_ba, 1);
        drive_usr(NOP, 2'd0, 12'h000);

        // R7: first interval tick
        run_to(62);
        chk("R7 req before interval", refresh_req, 0);
        tick();
        chk("R7 req at interval", refresh_req, 1);
        chk("R8 grant kept while busy", usr_grant, 1);
        for (int c = 64; c <= 66; c++) begin
            tick();
            chk("R8 no refresh while busy", pin_cmd, NOP);
            chk("R8 grant held", usr_grant, 1);
        end
        usr_idle = 1'b1;
        drive_usr(ACT, 2'd1, 12'h111);
        tick();
        chk("R9 refresh issued", pin_cmd, REF);
        chk("R9 grant low", usr_grant, 0);
        for (int c = 68; c <= 73; c++) begin
            tick();
            chk("R9,R10 NOP during recovery", pin_cmd, NOP);
            chk("R9 grant low in recovery", usr_grant, 0);
            if (c == 68) chk("R12 req cleared", refresh_req, 0);
        end
        drive_usr(NOP, 2'd0, 12'h000);
        usr_idle = 1'b0;
        tick();
        chk("R9 grant returns", usr_grant, 1);
        chk("R9 pins after return", pin_cmd, NOP);

        // R11: let eight refreshes pile up
        run_to(382);
        chk("R8 grant with req below ceiling", usr_grant, 1);
        chk("R7 req pending", refresh_req, 1);
        drive_usr(ACT, 2'd3, 12'h0F0);
        tick();
        chk("R11 grant drops at ceiling", usr_grant, 0);
        chk("R11,R10 NOP at ceiling", pin_cmd, NOP);
        tick();
        chk("R11 forced precharge", pin_cmd, PRE);
        chk("R11,R3 forced precharge-all", mem_addr, 12'h400);
        tick();
        chk("R11 gap after precharge", pin_cmd, NOP);
        tick();
        chk("R11,R4 forced refresh", pin_cmd, REF);
        run_to(392);
        chk("R11 grant low in recovery", usr_grant, 0);
        drive_usr(NOP, 2'd0, 12'h000);
        tick();
        chk("R11 grant back", usr_grant, 1);
        chk("R12 req still pending", refresh_req, 1);
        usr_idle = 1'b1;

        // R12: drain; a timer tick lands in the middle of it
        ref_cnt = 0;
        for (int c = 394; c <= 460; c++) begin
            tick();
            if (pin_cmd == REF) ref_cnt++;
        end
        chk("R12 drained refresh count", ref_cnt, 8);
        chk("R12 req low after drain", refresh_req, 0);
        chk("R12 grant after drain", usr_grant, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule